// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one 32-bit fixed-length instruction word into the control and operand information that an execution datapath needs. It is purely combinational: the word enters, and within the same cycle the block delivers the opcode, the three register address fields, the shift amount and the function code. It also reports which of the three encoding formats the word uses. Alongside these it drives the ALU operation, the operand source, the register-write controls with the destination register, the memory and flow-control strobes, and the 32-bit extended immediate.

Each opcode picks its own immediate extension. Signed arithmetic, compares, memory offsets and branch offsets sign-extend the low 16 bits. The three logical-immediate forms zero-extend them. The upper-immediate load moves the constant into the top half and clears the bottom half. A word outside the supported set raises the illegal flag and forces every write and flow-control strobe low, so the datapath can carry the word through without changing any state.

Top module: `instr_decoder`

## Requirements
- R1: For every word, `opcode_o` is bits 31:26, `rs_o` is bits 25:21, `rt_o` is bits 20:16, `rd_o` is bits 15:11, `shamt_o` is bits 10:6 and `funct_o` is bits 5:0.
- R2: `fmt_o` is 0 for a legal register-format word (opcode 0x00), 2 for the two jump opcodes 0x02 and 0x03, 1 for every other legal opcode, and 3 for an illegal word.
- R3: With opcode 0x00, the function codes 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A set-less-than and 0x2B unsigned set-less-than produce `alu_op_o` 2, 3, 4, 5, 6 and 7. Each of them sets `reg_we_o`, gives `dst_sel_o` 0 and makes `wr_addr_o` equal to the rd field.
- R4: With opcode 0x00, function code 0x20 gives ALU op 0 (add) and 0x22 gives ALU op 1 (subtract), both with `ovf_trap_o` set. 0x21 and 0x23 give the same ALU ops with `ovf_trap_o` clear. All four write rd.
- R5: Opcodes 0x08, 0x09, 0x0A and 0x0B give ALU ops 0, 0, 6 and 7. `ovf_trap_o` is set only for 0x08. Each of these opcodes sign-extends the immediate, sets `alu_src_imm_o` and writes register rt (`dst_sel_o` 1).
- R6: Opcodes 0x0C, 0x0D and 0x0E give ALU ops 2, 3 and 4. Their `imm_ext_o` is the 16-bit immediate with zeros above it. Each writes rt with `alu_src_imm_o` set.
- R7: Opcode 0x0F gives ALU op 8 (pass operand B). `imm_ext_o` is the 16-bit immediate in bits 31:16 with bits 15:0 cleared. It writes rt.
- R8: Opcode 0x23 sets `mem_rd_o` and writes rt. Opcode 0x2B sets `mem_wr_o` and writes no register. Both use ALU op 0, set `alu_src_imm_o` and sign-extend the offset.
- R9: Opcodes 0x04 and 0x05 set `branch_o` with ALU op 1 and a sign-extended offset. `branch_ne_o` is set only for 0x05. Neither writes a register.
- R10: Opcode 0x02 sets only `jump_o`. Opcode 0x03 sets `jump_o` and `reg_we_o` with `dst_sel_o` 2 and `wr_addr_o` 31. Opcode 0x00 with function code 0x08 sets `jump_o` and `jump_reg_o` and writes nothing.
- R11: Any other opcode, or opcode 0x00 with any other function code, sets `illegal_o`. It clears `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `branch_o`, `branch_ne_o`, `jump_o`, `jump_reg_o`, `alu_src_imm_o` and `ovf_trap_o`, and sets `alu_op_o` to 0.
- R12: Whenever no register is written, `dst_sel_o` is 0 and `wr_addr_o` equals the rd field. For every word outside R6 and R7, `imm_ext_o` is the sign-extended low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opcode_o | output | 6 | Primary operation field |
| rs_o | output | 5 | First source register address |
| rt_o | output | 5 | Second source / immediate destination register address |
| rd_o | output | 5 | Register-format destination address |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| fmt_o | output | 2 | Encoding format: 0 register, 1 immediate, 2 jump, 3 illegal |
| alu_op_o | output | 4 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu, 8 pass B |
| alu_src_imm_o | output | 1 | ALU operand B comes from the extended immediate |
| ovf_trap_o | output | 1 | Signed overflow must be checked on this add or subtract |
| reg_we_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination select: 0 rd, 1 rt, 2 link register 31 |
| wr_addr_o | output | 5 | Resolved destination register address |
| mem_rd_o | output | 1 | Memory word read |
| mem_wr_o | output | 1 | Memory word write |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch is taken on inequality rather than equality |
| jump_o | output | 1 | Unconditional transfer of control |
| jump_reg_o | output | 1 | Jump target comes from register rs |
| imm_ext_o | output | 32 | Extended immediate |
| illegal_o | output | 1 | Word is not a supported instruction |

## Verification
The hardest case to reach from the ports is a legal opcode 0x00 whose function code is one of the few supported values while the other fields carry arbitrary data, because a uniformly random word almost never lands there. The stimulus therefore chooses most opcodes, and most function codes under opcode 0x00, from the supported lists, fills every other bit at random, and mixes in fully random words to cover the illegal space. Directed words cover the extension boundaries: immediate 0x8000 and 0xFFFF under sign and zero extension, an upper-immediate load, the link write to register 31, the register jump, and illegal function codes next to legal ones.

// File: rtl/instr_decoder.sv
module instr_decoder (
  input  logic [31:0] instr_i,
  output logic [5:0]  opcode_o,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  shamt_o,
  output logic [5:0]  funct_o,
  output logic [1:0]  fmt_o,
  output logic [3:0]  alu_op_o,
  output logic        alu_src_imm_o,
  output logic        ovf_trap_o,
  output logic        reg_we_o,
  output logic [1:0]  dst_sel_o,
  output logic [4:0]  wr_addr_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        branch_o,
  output logic        branch_ne_o,
  output logic        jump_o,
  output logic        jump_reg_o,
  output logic [31:0] imm_ext_o,
  output logic        illegal_o
);

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [3:0] ALU_ADD  = 4'd0;
  localparam logic [3:0] ALU_SUB  = 4'd1;
  localparam logic [3:0] ALU_AND  = 4'd2;
  localparam logic [3:0] ALU_OR   = 4'd3;
  localparam logic [3:0] ALU_XOR  = 4'd4;
  localparam logic [3:0] ALU_NOR  = 4'd5;
  localparam logic [3:0] ALU_SLT  = 4'd6;
  localparam logic [3:0] ALU_SLTU = 4'd7;
  localparam logic [3:0] ALU_PASS = 4'd8;

  localparam logic [1:0] DST_RD = 2'd0;
  localparam logic [1:0] DST_RT = 2'd1;
  localparam logic [1:0] DST_RA = 2'd2;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_UPPER} ext_e;

  ext_e ext_mode;

  assign opcode_o = instr_i[31:26];
  assign rs_o     = instr_i[25:21];
  assign rt_o     = instr_i[20:16];
  assign rd_o     = instr_i[15:11];
  assign shamt_o  = instr_i[10:6];
  assign funct_o  = instr_i[5:0];

  always_comb begin
    fmt_o         = 2'd1;
    alu_op_o      = ALU_ADD;
    alu_src_imm_o = 1'b0;
    ovf_trap_o    = 1'b0;
    reg_we_o      = 1'b0;
    dst_sel_o     = DST_RD;
    mem_rd_o      = 1'b0;
    mem_wr_o      = 1'b0;
    branch_o      = 1'b0;
    branch_ne_o   = 1'b0;
    jump_o        = 1'b0;
    jump_reg_o    = 1'b0;
    illegal_o     = 1'b0;
    ext_mode      = EXT_SIGN;
    unique case (opcode_o)
      OP_REG: begin
        fmt_o    = 2'd0;
        reg_we_o = 1'b1;
        unique case (funct_o)
          6'h20: ovf_trap_o = 1'b1;
          6'h21: ;
          6'h22: begin alu_op_o = ALU_SUB; ovf_trap_o = 1'b1; end
          6'h23: alu_op_o = ALU_SUB;
          6'h24: alu_op_o = ALU_AND;
          6'h25: alu_op_o = ALU_OR;
          6'h26: alu_op_o = ALU_XOR;
          6'h27: alu_op_o = ALU_NOR;
          6'h2A: alu_op_o = ALU_SLT;
          6'h2B: alu_op_o = ALU_SLTU;
          6'h08: begin reg_we_o = 1'b0; jump_o = 1'b1; jump_reg_o = 1'b1; end
          default: begin reg_we_o = 1'b0; illegal_o = 1'b1; end
        endcase
      end
      OP_J:   begin fmt_o = 2'd2; jump_o = 1'b1; end
      OP_JAL: begin fmt_o = 2'd2; jump_o = 1'b1; reg_we_o = 1'b1; dst_sel_o = DST_RA; end
      OP_BEQ: begin alu_op_o = ALU_SUB; branch_o = 1'b1; end
      OP_BNE: begin alu_op_o = ALU_SUB; branch_o = 1'b1; branch_ne_o = 1'b1; end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI: begin
        alu_src_imm_o = 1'b1;
        reg_we_o      = 1'b1;
        dst_sel_o     = DST_RT;
        unique case (opcode_o)
          OP_ADDI:  ovf_trap_o = 1'b1;
          OP_SLTI:  alu_op_o = ALU_SLT;
          OP_SLTIU: alu_op_o = ALU_SLTU;
          OP_ANDI:  begin alu_op_o = ALU_AND; ext_mode = EXT_ZERO; end
          OP_ORI:   begin alu_op_o = ALU_OR;  ext_mode = EXT_ZERO; end
          OP_XORI:  begin alu_op_o = ALU_XOR; ext_mode = EXT_ZERO; end
          OP_LUI:   begin alu_op_o = ALU_PASS; ext_mode = EXT_UPPER; end
          default:  ;
        endcase
      end
      OP_LW: begin
        alu_src_imm_o = 1'b1;
        reg_we_o      = 1'b1;
        dst_sel_o     = DST_RT;
        mem_rd_o      = 1'b1;
      end
      OP_SW: begin
        alu_src_imm_o = 1'b1;
        mem_wr_o      = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
    if (illegal_o) fmt_o = 2'd3;
  end

  always_comb begin
    unique case (dst_sel_o)
      DST_RT:  wr_addr_o = rt_o;
      DST_RA:  wr_addr_o = 5'd31;
      default: wr_addr_o = rd_o;
    endcase
  end

  always_comb begin
    unique case (ext_mode)
      EXT_ZERO:  imm_ext_o = {16'h0000, instr_i[15:0]};
      EXT_UPPER: imm_ext_o = {instr_i[15:0], 16'h0000};
      default:   imm_ext_o = {{16{instr_i[15]}}, instr_i[15:0]};
    endcase
  end

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr_i,
  input logic [1:0]  fmt_o,
  input logic [3:0]  alu_op_o,
  input logic        alu_src_imm_o,
  input logic        reg_we_o,
  input logic [1:0]  dst_sel_o,
  input logic [4:0]  wr_addr_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        branch_o,
  input logic        branch_ne_o,
  input logic        jump_o,
  input logic        jump_reg_o,
  input logic [31:0] imm_ext_o,
  input logic        illegal_o
);

  always_comb begin
    assert_illegal_quiet_R11: assert (!illegal_o ||
      !(reg_we_o | mem_rd_o | mem_wr_o | branch_o | jump_o | jump_reg_o))
      else $error("illegal word left a strobe active");
    assert_illegal_fmt_R2: assert (illegal_o == (fmt_o == 2'd3))
      else $error("illegal flag and format disagree");
    assert_reg_dest_rd_R3: assert (!(reg_we_o && fmt_o == 2'd0) || wr_addr_o == instr_i[15:11])
      else $error("register-format write not to rd");
    assert_mem_addr_R8: assert (!(mem_rd_o || mem_wr_o) ||
      (!(mem_rd_o && mem_wr_o) && alu_op_o == 4'd0 && alu_src_imm_o &&
       imm_ext_o[31:16] == {16{instr_i[15]}}))
      else $error("memory access decode inconsistent");
    assert_store_nowrite_R8: assert (!mem_wr_o || !reg_we_o)
      else $error("store also writes a register");
    assert_branch_R9: assert (!branch_o || (!reg_we_o && alu_op_o == 4'd1 && !jump_o))
      else $error("branch decode inconsistent");
    assert_bne_R9: assert (!branch_ne_o || branch_o)
      else $error("inequality flag without branch");
    assert_upper_R7: assert (alu_op_o != 4'd8 ||
      (imm_ext_o[15:0] == 16'h0000 && imm_ext_o[31:16] == instr_i[15:0]))
      else $error("upper immediate misplaced");
    assert_link_R10: assert (!(jump_o && reg_we_o) || (wr_addr_o == 5'd31 && dst_sel_o == 2'd2))
      else $error("link write not to register 31");
    assert_jreg_R10: assert (!jump_reg_o || (jump_o && fmt_o == 2'd0))
      else $error("register jump decode inconsistent");
  end

endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .instr_i(instr_i), .fmt_o(fmt_o), .alu_op_o(alu_op_o), .alu_src_imm_o(alu_src_imm_o),
  .reg_we_o(reg_we_o), .dst_sel_o(dst_sel_o), .wr_addr_o(wr_addr_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .branch_o(branch_o), .branch_ne_o(branch_ne_o), .jump_o(jump_o),
  .jump_reg_o(jump_reg_o), .imm_ext_o(imm_ext_o), .illegal_o(illegal_o)
);

// File: tb/test_instr_decoder.sv
`timescale 1ns/1ps
module test_instr_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt, wr_addr;
  logic [1:0]  fmt, dst_sel;
  logic [3:0]  alu_op;
  logic        alu_src_imm, ovf_trap, reg_we, mem_rd, mem_wr, branch, branch_ne, jump, jump_reg, illegal;
  logic [31:0] imm_ext;

  instr_decoder i_instr_decoder (
    .instr_i(instr), .opcode_o(opcode), .rs_o(rs), .rt_o(rt), .rd_o(rd), .shamt_o(shamt),
    .funct_o(funct), .fmt_o(fmt), .alu_op_o(alu_op), .alu_src_imm_o(alu_src_imm),
    .ovf_trap_o(ovf_trap), .reg_we_o(reg_we), .dst_sel_o(dst_sel), .wr_addr_o(wr_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .branch_o(branch), .branch_ne_o(branch_ne),
    .jump_o(jump), .jump_reg_o(jump_reg), .imm_ext_o(imm_ext), .illegal_o(illegal)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [1:0]  e_fmt, e_dsel;
  logic [3:0]  e_alu;
  logic        e_src, e_ovf, e_we, e_mr, e_mw, e_br, e_bne, e_j, e_jr, e_ill;
  logic [31:0] e_imm;
  logic [4:0]  e_wr;
  string       tag;

  task automatic model(input logic [31:0] w);
    logic [5:0] op, fn;
    op = w[31:26]; fn = w[5:0];
    e_fmt = 2'd1; e_alu = 4'd0; e_src = 0; e_ovf = 0; e_we = 0; e_dsel = 2'd0;
    e_mr = 0; e_mw = 0; e_br = 0; e_bne = 0; e_j = 0; e_jr = 0; e_ill = 0;
    e_imm = {{16{w[15]}}, w[15:0]};
    tag = "R11";
    case (op)
      6'h00: begin
        e_fmt = 2'd0;
        case (fn)
          6'h20: begin tag = "R4"; e_ovf = 1; e_we = 1; end
          6'h21: begin tag = "R4"; e_we = 1; end
          6'h22: begin tag = "R4"; e_alu = 1; e_ovf = 1; e_we = 1; end
          6'h23: begin tag = "R4"; e_alu = 1; e_we = 1; end
          6'h24: begin tag = "R3"; e_alu = 2; e_we = 1; end
          6'h25: begin tag = "R3"; e_alu = 3; e_we = 1; end
          6'h26: begin tag = "R3"; e_alu = 4; e_we = 1; end
          6'h27: begin tag = "R3"; e_alu = 5; e_we = 1; end
          6'h2A: begin tag = "R3"; e_alu = 6; e_we = 1; end
          6'h2B: begin tag = "R3"; e_alu = 7; e_we = 1; end
          6'h08: begin tag = "R10"; e_j = 1; e_jr = 1; end
          default: e_ill = 1;
        endcase
      end
      6'h02: begin tag = "R10"; e_fmt = 2'd2; e_j = 1; end
      6'h03: begin tag = "R10"; e_fmt = 2'd2; e_j = 1; e_we = 1; e_dsel = 2'd2; end
      6'h04: begin tag = "R9"; e_alu = 1; e_br = 1; end
      6'h05: begin tag = "R9"; e_alu = 1; e_br = 1; e_bne = 1; end
      6'h08: begin tag = "R5"; e_src = 1; e_ovf = 1; e_we = 1; e_dsel = 1; end
      6'h09: begin tag = "R5"; e_src = 1; e_we = 1; e_dsel = 1; end
      6'h0A: begin tag = "R5"; e_alu = 6; e_src = 1; e_we = 1; e_dsel = 1; end
      6'h0B: begin tag = "R5"; e_alu = 7; e_src = 1; e_we = 1; e_dsel = 1; end
      6'h0C: begin tag = "R6"; e_alu = 2; e_src = 1; e_we = 1; e_dsel = 1; e_imm = {16'h0, w[15:0]}; end
      6'h0D: begin tag = "R6"; e_alu = 3; e_src = 1; e_we = 1; e_dsel = 1; e_imm = {16'h0, w[15:0]}; end
      6'h0E: begin tag = "R6"; e_alu = 4; e_src = 1; e_we = 1; e_dsel = 1; e_imm = {16'h0, w[15:0]}; end
      6'h0F: begin tag = "R7"; e_alu = 8; e_src = 1; e_we = 1; e_dsel = 1; e_imm = {w[15:0], 16'h0}; end
      6'h23: begin tag = "R8"; e_src = 1; e_we = 1; e_dsel = 1; e_mr = 1; end
      6'h2B: begin tag = "R8"; e_src = 1; e_mw = 1; end
      default: e_ill = 1;
    endcase
    if (e_ill) e_fmt = 2'd3;
    e_wr = (e_dsel == 2'd1) ? w[20:16] : (e_dsel == 2'd2) ? 5'd31 : w[15:11];
  endtask

  task automatic check(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s word=%08h actual=%0h expected=%0h", t, what, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    model(w);
    check("R1", "fields", {rs, rt, rd, shamt, opcode, funct},
          {w[25:21], w[20:16], w[15:11], w[10:6], w[31:26], w[5:0]});
    check("R2", "fmt", fmt, e_fmt);
    check(tag, "alu_op", alu_op, e_alu);
    check(tag, "src/ovf", {alu_src_imm, ovf_trap}, {e_src, e_ovf});
    check(tag, "write", {reg_we, dst_sel}, {e_we, e_dsel});
    check(e_we ? tag : "R12", "wr_addr", wr_addr, e_wr);
    check(tag, "mem", {mem_rd, mem_wr}, {e_mr, e_mw});
    check(tag, "flow", {branch, branch_ne, jump, jump_reg}, {e_br, e_bne, e_j, e_jr});
    check((tag == "R6" || tag == "R7") ? tag : "R12", "imm_ext", imm_ext, e_imm);
    check("R11", "illegal", illegal, e_ill);
  endtask

  function automatic logic [5:0] pick_op(input int k);
    case (k)
      0: return 6'h00; 1: return 6'h02; 2: return 6'h03; 3: return 6'h04;
      4: return 6'h05; 5: return 6'h08; 6: return 6'h09; 7: return 6'h0A;
      8: return 6'h0B; 9: return 6'h0C; 10: return 6'h0D; 11: return 6'h0E;
      12: return 6'h0F; 13: return 6'h23; 14: return 6'h2B;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [5:0] pick_fn(input int k);
    case (k)
      0: return 6'h20; 1: return 6'h21; 2: return 6'h22; 3: return 6'h23;
      4: return 6'h24; 5: return 6'h25; 6: return 6'h26; 7: return 6'h27;
      8: return 6'h2A; 9: return 6'h2B; default: return 6'h08;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    instr = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero word has function code 0, unsupported (R11)
    apply(32'h0000_0000);
    // directed corner cases
    apply({6'h08, 5'd3, 5'd7, 16'h8000});   // R5 sign-extend negative boundary
    apply({6'h0B, 5'd1, 5'd2, 16'hFFFF});   // R5 unsigned compare still sign-extends
    apply({6'h0C, 5'd4, 5'd5, 16'hFFFF});   // R6 zero-extend all ones
    apply({6'h0D, 5'd4, 5'd5, 16'h8001});   // R6
    apply({6'h0F, 5'd0, 5'd9, 16'hABCD});   // R7
    apply({6'h23, 5'd17, 5'd21, 16'hFFFC}); // R8 load negative offset
    apply({6'h2B, 5'd20, 5'd16, 16'h0010}); // R8 store
    apply({6'h05, 5'd16, 5'd17, 16'hFFF3}); // R9
    apply({6'h03, 26'h0000088});            // R10 link
    apply({6'h00, 5'd31, 15'h0, 6'h08});    // R10 register jump
    apply({6'h00, 5'd8, 5'd20, 5'd16, 5'd0, 6'h20}); // R4
    apply({6'h00, 5'd10, 5'd18, 5'd17, 5'd0, 6'h24}); // R3
    apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h18});   // R11 unsupported function
    apply({6'h3F, 26'h3FF_FFFF});                      // R11 unsupported opcode
    for (int i = 0; i < 4000; i++) begin
      w = $urandom;
      if (($urandom % 4) != 0) begin
        w[31:26] = pick_op($urandom % 16);
        if (w[31:26] == 6'h00 && ($urandom % 8) != 0) w[5:0] = pick_fn($urandom % 11);
      end
      apply(w);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule